// File: doc/BRIEF.md
# Loop-Exit Branch Predictor

This block spots conditional branches that behave like loop control. Such a branch resolves the same way for a run of outcomes and then resolves the other way exactly once. The block predicts that single opposite outcome by counting outcomes against a learned run length. A small fully associative table holds one entry per tracked branch address. Each entry stores the address tag, the dominant direction, the count of dominant outcomes in the current run, the learned run length and a confidence flag. The dominant direction is learned per entry, so both bottom-tested loops (taken, then one not-taken) and top-tested loops (not-taken, then one taken) are handled.

A fetch-side query presents a branch address and receives a hit flag, a direction and a confidence flag in the same cycle. An enclosing hybrid predictor uses the confidence flag to decide whether to follow this block. Resolved outcomes arrive on a valid/ready update port. The port never applies back-pressure: `upd_ready` is high at all times, and an update is accepted on every rising clock edge where `upd_valid` is high. Each accepted update is reflected in query results from the next cycle on.

Top module: `loop_exit_pred`

## Requirements
- R1: After reset every entry is empty, and any query reports pred_hit=0, pred_taken=0, pred_conf=0.
- R2: An update whose address misses allocates an entry. The dominant direction is set to the resolved outcome, the run count to 1, no run length is known and confidence is 0. A query of that address then hits and predicts that direction.
- R3: An update that hits and matches the dominant direction increments the run count. While the run count differs from the learned run length, the query predicts the dominant direction.
- R4: An update that hits with the opposite outcome and a non-zero run count ends a run. The run count is stored as the learned run length and the run count returns to 0. When a known run length equals the current run count, the query predicts the opposite of the dominant direction.
- R5: An entry becomes confident when a run ends with the same length as the previous recorded run. A run ending with a different length clears confidence and adopts the new length.
- R6: The dominant direction is learned per entry. An entry whose dominant direction is not-taken predicts taken (pred_taken=1) at the run end.
- R7: On allocation the victim is chosen in this order: the lowest-index empty entry, then the lowest-index non-confident entry, then an entry picked by a round-robin pointer. The pointer starts at index 0 and advances only when it is used.
- R8: The run count saturates at 2^CNT_W-1 (15 by default). A dominant outcome that arrives at saturation clears confidence and forgets the run length. A run ending at saturation records no run length.
- R9: upd_ready is always 1. A cycle with upd_valid=0 leaves every prediction unchanged.
- R10: An opposite outcome that arrives with a run count of 0 makes that outcome the new dominant direction. It sets the run count to 1 and clears the run length and confidence.
- R11: An address occupies at most one table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Resolved outcome present on the update port |
| upd_ready | output | 1 | Update port accepts; always 1 |
| upd_pc | input | LP_TAG_W (16) | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| lkp_pc | input | LP_TAG_W (16) | Address being queried |
| pred_hit | output | 1 | Query address is tracked |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_conf | output | 1 | Entry has seen two equal-length runs in a row |

## Verification
A query answer is combinational from the table, so it is available in the same cycle as the address. The effect of an update appears one rising edge after the update is accepted. The bench drives an update at a falling edge, lets the following rising edge accept it, and then drops valid. At the next falling edge it presents the query address and samples the outputs shortly after, so every check sees exactly one newly accepted update. Idle cycles and replacement checks are sampled at the same point, which makes each expected value depend only on the updates applied so far.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned LP_TAG_W = 16;
  localparam int unsigned LP_CNT_W = 4;

  typedef struct packed {
    logic                vld;
    logic [LP_TAG_W-1:0] tag;
    logic                dir;
    logic [LP_CNT_W-1:0] iter;
    logic [LP_CNT_W-1:0] trip;
    logic                known;
    logic                conf;
  } lp_entry_t;

  typedef enum logic [2:0] {
    ACT_ALLOC,
    ACT_COUNT,
    ACT_SAT,
    ACT_EXIT,
    ACT_FLIP
  } lp_act_e;
endpackage

// File: rtl/lp_match.sv
module lp_match
  import lp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  lp_entry_t [ENTRIES-1:0] tbl,
  input  logic [LP_TAG_W-1:0]     pc,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx,
  output logic [ENTRIES-1:0]      vec
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      vec[i] = tbl[i].vld && (tbl[i].tag == pc);
      if (vec[i] && !hit) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lp_victim.sv
module lp_victim
  import lp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  lp_entry_t [ENTRIES-1:0] tbl,
  input  logic [IDX_W-1:0]        rr,
  output logic [IDX_W-1:0]        idx,
  output logic                    use_rr
);
  logic             have_free, have_weak;
  logic [IDX_W-1:0] free_idx, weak_idx;

  always_comb begin
    have_free = 1'b0;
    have_weak = 1'b0;
    free_idx  = '0;
    weak_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!tbl[i].vld && !have_free) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
      if (tbl[i].vld && !tbl[i].conf && !have_weak) begin
        have_weak = 1'b1;
        weak_idx  = IDX_W'(i);
      end
    end
    if (have_free) begin
      idx    = free_idx;
      use_rr = 1'b0;
    end else if (have_weak) begin
      idx    = weak_idx;
      use_rr = 1'b0;
    end else begin
      idx    = rr;
      use_rr = 1'b1;
    end
  end
endmodule

// File: rtl/lp_train.sv
module lp_train
  import lp_pkg::*;
(
  input  lp_entry_t           cur,
  input  logic                hit,
  input  logic [LP_TAG_W-1:0] pc,
  input  logic                taken,
  output lp_entry_t           nxt,
  output lp_act_e             act
);
  localparam logic [LP_CNT_W-1:0] CNT_MAX = {LP_CNT_W{1'b1}};

  always_comb begin
    nxt = cur;
    if (!hit) begin
      act       = ACT_ALLOC;
      nxt       = '0;
      nxt.vld   = 1'b1;
      nxt.tag   = pc;
      nxt.dir   = taken;
      nxt.iter  = LP_CNT_W'(1);
    end else if (taken == cur.dir) begin
      if (cur.iter == CNT_MAX) begin
        act       = ACT_SAT;
        nxt.conf  = 1'b0;
        nxt.known = 1'b0;
      end else begin
        act      = ACT_COUNT;
        nxt.iter = cur.iter + 1'b1;
      end
    end else if (cur.iter == '0) begin
      act       = ACT_FLIP;
      nxt.dir   = taken;
      nxt.iter  = LP_CNT_W'(1);
      nxt.known = 1'b0;
      nxt.conf  = 1'b0;
    end else begin
      act      = ACT_EXIT;
      nxt.iter = '0;
      if (cur.iter == CNT_MAX) begin
        nxt.known = 1'b0;
        nxt.conf  = 1'b0;
      end else begin
        nxt.trip  = cur.iter;
        nxt.known = 1'b1;
        nxt.conf  = cur.known && (cur.trip == cur.iter);
      end
    end
  end
endmodule

// File: rtl/loop_exit_pred.sv
module loop_exit_pred
  import lp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_valid,
  output logic                upd_ready,
  input  logic [LP_TAG_W-1:0] upd_pc,
  input  logic                upd_taken,
  input  logic [LP_TAG_W-1:0] lkp_pc,
  output logic                pred_hit,
  output logic                pred_taken,
  output logic                pred_conf
);
  lp_entry_t [ENTRIES-1:0] tbl;
  logic [IDX_W-1:0]        rr;

  logic                    lkp_hit, upd_hit, vic_rr, fire;
  logic [IDX_W-1:0]        lkp_idx, upd_idx, vic_idx, widx;
  logic [ENTRIES-1:0]      lkp_vec, upd_vec;
  lp_entry_t               lkp_e, nxt;
  lp_act_e                 act;

  assign upd_ready = 1'b1;
  assign fire      = upd_valid && upd_ready;

  lp_match #(.ENTRIES(ENTRIES)) u_lkp_match (
    .tbl(tbl), .pc(lkp_pc), .hit(lkp_hit), .idx(lkp_idx), .vec(lkp_vec)
  );

  lp_match #(.ENTRIES(ENTRIES)) u_upd_match (
    .tbl(tbl), .pc(upd_pc), .hit(upd_hit), .idx(upd_idx), .vec(upd_vec)
  );

  lp_victim #(.ENTRIES(ENTRIES)) u_victim (
    .tbl(tbl), .rr(rr), .idx(vic_idx), .use_rr(vic_rr)
  );

  lp_train u_train (
    .cur(tbl[upd_idx]), .hit(upd_hit), .pc(upd_pc), .taken(upd_taken),
    .nxt(nxt), .act(act)
  );

  assign widx = upd_hit ? upd_idx : vic_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
      rr  <= '0;
    end else if (fire) begin
      tbl[widx] <= nxt;
      if (!upd_hit && vic_rr) begin
        rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
      end
    end
  end

  assign lkp_e      = tbl[lkp_idx];
  assign pred_hit   = lkp_hit;
  assign pred_conf  = lkp_hit && lkp_e.conf;
  assign pred_taken = lkp_hit &&
                      ((lkp_e.known && (lkp_e.iter == lkp_e.trip)) ? !lkp_e.dir : lkp_e.dir);

  // R11
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_vec));
  // R11
  lkp_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lkp_vec));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(tbl));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    // R5
    conf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tbl[i].conf) |-> ($past(fire) && $past(act) == ACT_EXIT));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act == ACT_COUNT && widx == IDX_W'(i)) |=>
        tbl[i].iter == $past(tbl[i].iter) + 1'b1);
    // R4
    exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act == ACT_EXIT && widx == IDX_W'(i)) |=> tbl[i].iter == '0);
    // R8
    sat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act == ACT_SAT && widx == IDX_W'(i)) |=> (!tbl[i].conf && !tbl[i].known));
  end
endmodule

// File: tb/loop_exit_pred_bench.sv
`timescale 1ns/1ps
module loop_exit_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [15:0] lkp_pc = '0;
  logic        pred_hit, pred_taken, pred_conf;

  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  loop_exit_pred u_loop_exit_pred (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .lkp_pc(lkp_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_conf(pred_conf)
  );

  localparam logic [15:0] PA = 16'h0040, PB = 16'h0080, PC = 16'h00C0,
                          PD = 16'h0100, PE = 16'h0140, PF = 16'h0180,
                          PG = 16'h01C0, PH = 16'h0200;

  // {outcome, expected pred_taken, expected pred_conf}, address PA, hit expected
  localparam int NV = 20;
  localparam logic [2:0] VEC [NV] = '{
    3'b110, 3'b110, 3'b110, 3'b010, 3'b110, 3'b110, 3'b100, 3'b011,
    3'b111, 3'b111, 3'b101, 3'b011, 3'b111, 3'b111, 3'b010, 3'b110,
    3'b100, 3'b011, 3'b111, 3'b101
  };

  task automatic upd(input logic [15:0] pc, input logic t);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic chk(input logic [15:0] pc, input logic eh, input logic et,
                     input logic ec, input string req);
    lkp_pc = pc;
    #1;
    nvec++;
    if (pred_hit !== eh || pred_taken !== et || pred_conf !== ec) begin
      nerr++;
      $display("FAIL %s pc=%h got hit/taken/conf=%b%b%b expected %b%b%b",
               req, pc, pred_hit, pred_taken, pred_conf, eh, et, ec);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 empty after reset; R9 always ready
    chk(PA, 1'b0, 1'b0, 1'b0, "R1");
    nvec++;
    if (upd_ready !== 1'b1) begin
      nerr++;
      $display("FAIL R9 upd_ready got %b expected 1", upd_ready);
    end

    // R2 R3 R4 R5: bottom-tested loop of four, then a length change
    for (int k = 0; k < NV; k++) begin
      upd(PA, VEC[k][2]);
      chk(PA, 1'b1, VEC[k][1], VEC[k][0], "R2 R3 R4 R5 table");
    end

    // R9 a not-valid cycle carrying an exit outcome changes nothing
    upd_valid = 1'b0; upd_pc = PA; upd_taken = 1'b0;
    @(negedge clk);
    chk(PA, 1'b1, 1'b0, 1'b1, "R9");

    // R6 top-tested loop: not-taken twice then taken
    upd(PB, 1'b0); upd(PB, 1'b0); upd(PB, 1'b1); upd(PB, 1'b0); upd(PB, 1'b0);
    chk(PB, 1'b1, 1'b1, 1'b0, "R6");
    upd(PB, 1'b1);
    chk(PB, 1'b1, 1'b0, 1'b1, "R6");

    // R10 two opposite outcomes in a row flip the dominant direction
    upd(PC, 1'b1); upd(PC, 1'b0);
    chk(PC, 1'b1, 1'b1, 1'b0, "R10");
    upd(PC, 1'b0);
    chk(PC, 1'b1, 1'b0, 1'b0, "R10");

    // R8 saturation of the run count
    upd(PD, 1'b1); upd(PD, 1'b0); upd(PD, 1'b1); upd(PD, 1'b0);
    chk(PD, 1'b1, 1'b1, 1'b1, "R5");
    for (int k = 0; k < 15; k++) upd(PD, 1'b1);
    chk(PD, 1'b1, 1'b1, 1'b1, "R8");
    upd(PD, 1'b1);
    chk(PD, 1'b1, 1'b1, 1'b0, "R8");
    upd(PD, 1'b0);
    upd(PD, 1'b1); upd(PD, 1'b0);
    chk(PD, 1'b1, 1'b1, 1'b0, "R8");

    // R7 full table: lowest non-confident entry (PC) is the victim
    upd(PE, 1'b1);
    chk(PC, 1'b0, 1'b0, 1'b0, "R7");
    chk(PE, 1'b1, 1'b1, 1'b0, "R7");
    chk(PD, 1'b1, 1'b1, 1'b0, "R7");
    upd(PE, 1'b0); upd(PE, 1'b1); upd(PE, 1'b0);
    upd(PD, 1'b1); upd(PD, 1'b0);
    chk(PD, 1'b1, 1'b1, 1'b1, "R5");
    // R7 all confident: round robin starts at entry 0 (PA)
    upd(PF, 1'b1);
    chk(PA, 1'b0, 1'b0, 1'b0, "R7");
    chk(PF, 1'b1, 1'b1, 1'b0, "R7");
    // R7 non-confident PF goes before the pointer's choice
    upd(PG, 1'b1);
    chk(PF, 1'b0, 1'b0, 1'b0, "R7");
    chk(PB, 1'b1, 1'b0, 1'b1, "R7");
    upd(PG, 1'b0); upd(PG, 1'b1); upd(PG, 1'b0);
    // R7 pointer advanced to entry 1 (PB)
    upd(PH, 1'b1);
    chk(PB, 1'b0, 1'b0, 1'b0, "R7");
    chk(PH, 1'b1, 1'b1, 1'b0, "R7");
    chk(PG, 1'b1, 1'b1, 1'b1, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule